// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block produces the drive pattern for a direct-drive liquid-crystal panel with four common lines and twenty-eight segment lines. For each pin it outputs a 2-bit level code. The code picks one of four analog levels: ground, the lower bias tap, the upper bias tap, or the top supply. A resistor ladder and analog switches outside the block turn that code into a voltage. A frame-clock enable moves the sequencer from one common slot to the next. After the last slot the frame ends, and the drive polarity flips, so no pixel sees a net DC voltage.

Software programs the block through a simple write port. Four row registers hold the segment pattern, one per common line. A control register holds the duty/bias combination and the display enable. A port register lets the eight highest segment pins, in two groups of four, serve as plain logic outputs. Row data and mode changes are double-buffered and reach the panel only at a frame boundary, so no frame ever shows a mix of old and new content.

Top module: `lcd_mux_drive`

## Requirements
- R1: After reset the display is off, the mode is static, the slot and polarity are zero, all row and port registers are cleared, and every COM and SEG output carries code 0.
- R2: Level codes are 0 = ground, 1 = lower bias tap, 2 = upper bias tap, 3 = top supply. In static and half-bias modes, code 2 never appears; the middle level is always code 1.
- R3: Mode field values are 0 static (duty 1), 1 duty 2 / half bias, 2 duty 3 / half bias, 3 duty 3 / third bias, 4 duty 4 / third bias. A write that carries a value from 5 to 7 leaves the pending mode unchanged; the display-enable bit of that same write still takes effect.
- R4: Each cycle with `tick_i` high moves the slot up by one. The tick in the last slot of the active duty ends the frame: the slot returns to 0 and the polarity inverts.
- R5: With the display on, the common in the current slot outputs 3 at polarity 0 and 0 at polarity 1. Any other common, including those at or above the duty count, outputs 1 at polarity 0 and 2 at polarity 1 in third bias, and 1 in half bias. In static mode every common follows the selected pattern.
- R6: With the display on, a lit segment outputs 0 at polarity 0 and 3 at polarity 1. An unlit segment outputs 2/1 (polarity 0/1) in third bias, 1 in half bias, and 3/0 in static mode.
- R7: With the display off, every COM output and every SEG pin not in port mode carries code 0. The display enable takes effect at the clock edge that captures the write.
- R8: A row write, and a mode write, becomes visible on the outputs only at the tick that ends the current frame. A write that lands in the same cycle as that tick waits for the following frame.
- R9: When port-group bit g is 1, segments 20+4g to 23+4g become port pins: segment 20+i outputs code 3 if port data bit i is 1, else 0. This holds whatever the display state, and port writes take effect at the next clock edge.
- R10: Register map: addresses 0 to 3 are the rows for commons 0 to 3, where data bit j lights segment j. Address 4 is control: bits 2:0 hold the mode, bit 3 the display enable. Address 5 holds port data in bits 7:0 and the group selects in bits 9:8. Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Frame-clock enable; advances the common slot |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 28 | Register write data |
| com_lvl_o | output | 8 | Level codes for commons; common c at bits 2c+1:2c |
| seg_lvl_o | output | 56 | Level codes for segments; segment j at bits 2j+1:2j |

## Verification
Every output is a function of registered state only. Control and port writes therefore appear after the one clock edge that captures them, and a tick moves slot and polarity at that same edge. Row and mode writes need one more step: they wait in shadow storage until the edge of the tick that closes the frame. The bench drives its inputs on falling edges and updates a behavioural model on rising edges, using the same capture rules. It then compares all 64 output bits to that model on every falling edge. The directed checks are placed so that they read the outputs at the falling edge just after the frame-closing tick, or just after the write edge, and never earlier.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_GND = 2'd0;
  localparam lvl_t LVL_LO  = 2'd1;
  localparam lvl_t LVL_HI  = 2'd2;
  localparam lvl_t LVL_TOP = 2'd3;

  typedef enum logic [2:0] {
    MODE_STATIC = 3'd0,
    MODE_D2_B2  = 3'd1,
    MODE_D3_B2  = 3'd2,
    MODE_D3_B3  = 3'd3,
    MODE_D4_B3  = 3'd4
  } mode_e;

  function automatic logic mode_valid(logic [2:0] m);
    return m <= 3'd4;
  endfunction

  function automatic logic [2:0] duty_of(mode_e m);
    case (m)
      MODE_STATIC:            return 3'd1;
      MODE_D2_B2:             return 3'd2;
      MODE_D3_B2, MODE_D3_B3: return 3'd3;
      default:                return 3'd4;
    endcase
  endfunction

  function automatic logic third_bias(mode_e m);
    return (m == MODE_D3_B3) || (m == MODE_D4_B3);
  endfunction

  // sel: common owns the current slot
  function automatic lvl_t com_level(mode_e m, logic sel, logic pol);
    if (m == MODE_STATIC || sel) return pol ? LVL_GND : LVL_TOP;
    if (third_bias(m))           return pol ? LVL_HI : LVL_LO;
    return LVL_LO;
  endfunction

  function automatic lvl_t seg_level(mode_e m, logic on, logic pol);
    if (on)                 return pol ? LVL_TOP : LVL_GND;
    if (m == MODE_STATIC)   return pol ? LVL_GND : LVL_TOP;
    if (third_bias(m))      return pol ? LVL_LO : LVL_HI;
    return LVL_LO;
  endfunction
endpackage

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq #(
  parameter int N_COM  = 4,
  parameter int SLOT_W = (N_COM > 1) ? $clog2(N_COM) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [2:0]        duty_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              pol_o,
  output logic              frame_end_o
);
  logic [SLOT_W-1:0] slot_q;
  logic              pol_q;

  assign frame_end_o = tick_i && ((32'(slot_q) + 32'd1) == 32'(duty_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      pol_q  <= 1'b0;
    end else if (tick_i) begin
      slot_q <= frame_end_o ? '0 : slot_q + 1'b1;
      if (frame_end_o) pol_q <= ~pol_q;
    end
  end

  assign slot_o = slot_q;
  assign pol_o  = pol_q;
endmodule

// File: rtl/lcd_seg_store.sv
module lcd_seg_store #(
  parameter int N_COM = 4,
  parameter int N_SEG = 28,
  parameter int IDX_W = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [N_SEG-1:0]             wr_data_i,
  input  logic                         commit_i,
  output logic [N_COM-1:0][N_SEG-1:0]  rows_o
);
  for (genvar r = 0; r < N_COM; r++) begin : g_row
    logic [N_SEG-1:0] shadow_q, active_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        if (commit_i) active_q <= shadow_q;
        if (wr_en_i && wr_idx_i == IDX_W'(r)) shadow_q <= wr_data_i;
      end
    end
    assign rows_o[r] = active_q;
  end
endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_mux_pkg::*;
#(
  parameter int N_COM   = 4,
  parameter int N_SEG   = 28,
  parameter int SH_BASE = 20,
  parameter int N_SH    = 8,
  parameter int GRP_W   = 4,
  parameter int N_GRP   = N_SH / GRP_W,
  parameter int SLOT_W  = 2
) (
  input  mode_e                       mode_i,
  input  logic [SLOT_W-1:0]           slot_i,
  input  logic                        pol_i,
  input  logic                        disp_i,
  input  logic [N_COM-1:0][N_SEG-1:0] rows_i,
  input  logic [N_GRP-1:0]            port_sel_i,
  input  logic [N_SH-1:0]             port_i,
  output lvl_t [N_COM-1:0]            com_lvl_o,
  output lvl_t [N_SEG-1:0]            seg_lvl_o
);
  logic [2:0] duty;
  assign duty = duty_of(mode_i);

  for (genvar c = 0; c < N_COM; c++) begin : g_com
    logic sel;
    assign sel = (32'(c) < 32'(duty)) && (slot_i == SLOT_W'(c));
    assign com_lvl_o[c] = disp_i ? com_level(mode_i, sel, pol_i) : LVL_GND;
  end

  for (genvar j = 0; j < N_SEG; j++) begin : g_seg
    lvl_t lcd_lvl;
    assign lcd_lvl = disp_i ? seg_level(mode_i, rows_i[slot_i][j], pol_i) : LVL_GND;
    if (j >= SH_BASE && j < SH_BASE + N_SH) begin : g_shared
      assign seg_lvl_o[j] = port_sel_i[(j - SH_BASE) / GRP_W]
                          ? (port_i[j - SH_BASE] ? LVL_TOP : LVL_GND) : lcd_lvl;
    end else begin : g_plain
      assign seg_lvl_o[j] = lcd_lvl;
    end
  end
endmodule

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive
  import lcd_mux_pkg::*;
#(
  parameter int N_COM   = 4,
  parameter int N_SEG   = 28,
  parameter int SH_BASE = 20,
  parameter int N_SH    = 8,
  parameter int GRP_W   = 4,
  parameter int ADDR_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [N_SEG-1:0]        wr_data_i,
  output logic [N_COM*LVL_W-1:0]  com_lvl_o,
  output logic [N_SEG*LVL_W-1:0]  seg_lvl_o
);
  localparam int N_GRP  = N_SH / GRP_W;
  localparam int SLOT_W = (N_COM > 1) ? $clog2(N_COM) : 1;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_COM);
  localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(N_COM + 1);

  mode_e              mode_pend_q, mode_q;
  logic               disp_q;
  logic [N_GRP-1:0]   port_sel_q;
  logic [N_SH-1:0]    port_q;
  logic [SLOT_W-1:0]  slot;
  logic               pol, frame_end, row_wr;
  logic [N_COM-1:0][N_SEG-1:0] rows;
  lvl_t [N_COM-1:0]   com_lvl;
  lvl_t [N_SEG-1:0]   seg_lvl;

  assign row_wr = wr_en_i && (32'(wr_addr_i) < N_COM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_pend_q <= MODE_STATIC;
      mode_q      <= MODE_STATIC;
      disp_q      <= 1'b0;
      port_sel_q  <= '0;
      port_q      <= '0;
    end else begin
      if (frame_end) mode_q <= mode_pend_q;
      if (wr_en_i && wr_addr_i == CTRL_ADDR) begin
        if (mode_valid(wr_data_i[2:0])) mode_pend_q <= mode_e'(wr_data_i[2:0]);
        disp_q <= wr_data_i[3];
      end
      if (wr_en_i && wr_addr_i == PORT_ADDR) begin
        port_q     <= wr_data_i[N_SH-1:0];
        port_sel_q <= wr_data_i[N_SH +: N_GRP];
      end
    end
  end

  lcd_frame_seq #(.N_COM(N_COM), .SLOT_W(SLOT_W)) u_seq (
    .clk_i, .rst_ni, .tick_i,
    .duty_i(duty_of(mode_q)), .slot_o(slot), .pol_o(pol), .frame_end_o(frame_end)
  );

  lcd_seg_store #(.N_COM(N_COM), .N_SEG(N_SEG), .IDX_W(ADDR_W)) u_store (
    .clk_i, .rst_ni, .wr_en_i(row_wr), .wr_idx_i(wr_addr_i),
    .wr_data_i, .commit_i(frame_end), .rows_o(rows)
  );

  lcd_level_map #(.N_COM(N_COM), .N_SEG(N_SEG), .SH_BASE(SH_BASE), .N_SH(N_SH),
                  .GRP_W(GRP_W), .N_GRP(N_GRP), .SLOT_W(SLOT_W)) u_map (
    .mode_i(mode_q), .slot_i(slot), .pol_i(pol), .disp_i(disp_q), .rows_i(rows),
    .port_sel_i(port_sel_q), .port_i(port_q), .com_lvl_o(com_lvl), .seg_lvl_o(seg_lvl)
  );

  assign com_lvl_o = com_lvl;
  assign seg_lvl_o = seg_lvl;
endmodule

// File: rtl/lcd_mux_drive_chk.sv
module lcd_mux_drive_chk
  import lcd_mux_pkg::*;
#(
  parameter int N_COM   = 4,
  parameter int N_SEG   = 28,
  parameter int SH_BASE = 20,
  parameter int N_SH    = 8,
  parameter int GRP_W   = 4,
  parameter int N_GRP   = N_SH / GRP_W,
  parameter int SLOT_W  = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     tick_i,
  input logic [2:0]               mode_i,
  input logic [SLOT_W-1:0]        slot_i,
  input logic                     pol_i,
  input logic                     disp_i,
  input logic [N_GRP-1:0]         port_sel_i,
  input logic [N_COM*N_SEG-1:0]   rows_i,
  input logic [N_COM*LVL_W-1:0]   com_lvl_i,
  input logic [N_SEG*LVL_W-1:0]   seg_lvl_i
);
  logic [2:0] duty;
  logic       last, any_hi, port_bad;
  assign duty = duty_of(mode_e'(mode_i));
  assign last = tick_i && ((32'(slot_i) + 32'd1) == 32'(duty));

  always_comb begin
    any_hi   = 1'b0;
    port_bad = 1'b0;
    for (int c = 0; c < N_COM; c++) if (com_lvl_i[c*LVL_W +: LVL_W] == LVL_HI) any_hi = 1'b1;
    for (int j = 0; j < N_SEG; j++) begin
      if (seg_lvl_i[j*LVL_W +: LVL_W] == LVL_HI) any_hi = 1'b1;
      if (j >= SH_BASE && j < SH_BASE + N_SH && port_sel_i[(j - SH_BASE) / GRP_W] &&
          seg_lvl_i[j*LVL_W +: LVL_W] != LVL_GND && seg_lvl_i[j*LVL_W +: LVL_W] != LVL_TOP)
        port_bad = 1'b1;
    end
  end

  a_r2_no_upper_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !third_bias(mode_e'(mode_i)) |-> !any_hi);
  a_r4_slot_in_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(slot_i) < 32'(duty));
  a_r4_pol_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> pol_i != $past(pol_i));
  a_r4_pol_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable(pol_i));
  a_r8_rows_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable(rows_i) && $stable(mode_i));
  a_r7_dark_com: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_i |-> com_lvl_i == '0);
  a_r9_port_rails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_bad);
endmodule

bind lcd_mux_drive lcd_mux_drive_chk #(
  .N_COM(N_COM), .N_SEG(N_SEG), .SH_BASE(SH_BASE), .N_SH(N_SH),
  .GRP_W(GRP_W), .N_GRP(N_GRP), .SLOT_W(SLOT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .mode_i(mode_q),
  .slot_i(slot), .pol_i(pol), .disp_i(disp_q), .port_sel_i(port_sel_q),
  .rows_i(rows), .com_lvl_i(com_lvl_o), .seg_lvl_i(seg_lvl_o)
);

// File: tb/tb_lcd_mux_drive.sv
module tb_lcd_mux_drive;
  localparam int NC = 4, NS = 28;

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [NS-1:0] wr_data_i = '0;
  logic [NC*2-1:0] com_lvl_o;
  logic [NS*2-1:0] seg_lvl_o;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  lcd_mux_drive dut (.clk_i(clk), .rst_ni, .tick_i, .wr_en_i, .wr_addr_i, .wr_data_i,
                     .com_lvl_o, .seg_lvl_o);

  // reference model state
  bit [NS-1:0] m_sh[NC], m_act[NC];
  int m_mode_p, m_mode, m_slot;
  bit m_pol, m_disp;
  bit [1:0] m_sel;
  bit [7:0] m_port;

  function automatic int duty(int m);
    if (m == 0) return 1;
    if (m == 1) return 2;
    if (m <= 3) return 3;
    return 4;
  endfunction

  function automatic bit third(int m);
    return m == 3 || m == 4;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_sh[i]) begin m_sh[i] = '0; m_act[i] = '0; end
      m_mode_p = 0; m_mode = 0; m_slot = 0; m_pol = 0; m_disp = 0; m_sel = 0; m_port = 0;
    end else begin
      if (tick_i) begin
        if (m_slot == duty(m_mode) - 1) begin
          m_slot = 0; m_pol = !m_pol;
          foreach (m_act[i]) m_act[i] = m_sh[i];
          m_mode = m_mode_p;
        end else m_slot++;
      end
      if (wr_en_i) begin
        if (wr_addr_i < 4) m_sh[wr_addr_i] = wr_data_i;
        else if (wr_addr_i == 4) begin
          if (wr_data_i[2:0] <= 4) m_mode_p = wr_data_i[2:0];
          m_disp = wr_data_i[3];
        end else if (wr_addr_i == 5) begin
          m_port = wr_data_i[7:0]; m_sel = wr_data_i[9:8];
        end
      end
    end
  end

  function automatic int exp_com(int c);
    if (!m_disp) return 0;
    if (m_mode == 0 || (c < duty(m_mode) && c == m_slot)) return m_pol ? 0 : 3;
    if (third(m_mode)) return m_pol ? 2 : 1;
    return 1;
  endfunction

  function automatic int exp_seg(int j);
    if (j >= 20 && m_sel[(j-20)/4]) return m_port[j-20] ? 3 : 0;
    if (!m_disp) return 0;
    if (m_act[m_slot][j]) return m_pol ? 3 : 0;
    if (m_mode == 0) return m_pol ? 0 : 3;
    if (third(m_mode)) return m_pol ? 1 : 2;
    return 1;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      logic [NC*2-1:0] ec;
      logic [NS*2-1:0] es;
      for (int c = 0; c < NC; c++) ec[c*2 +: 2] = 2'(exp_com(c));
      for (int j = 0; j < NS; j++) es[j*2 +: 2] = 2'(exp_seg(j));
      check({cur_req, " model"}, {seg_lvl_o, com_lvl_o}, {es, ec});
    end
  end

  function automatic logic [1:0] seg(int j); return seg_lvl_o[j*2 +: 2]; endfunction
  function automatic logic [1:0] com(int c); return com_lvl_o[c*2 +: 2]; endfunction

  task automatic wr(int a, logic [NS-1:0] d, bit tk = 0);
    @(negedge clk); wr_en_i = 1; wr_addr_i = 3'(a); wr_data_i = d; tick_i = tk;
    @(negedge clk); wr_en_i = 0; tick_i = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1;
      @(negedge clk); tick_i = 0;
    end
  endtask

  task automatic run_mode(int m, string req);
    cur_req = req;
    wr(4, NS'(8 | m));
    for (int r = 0; r < 4; r++) wr(r, NS'($urandom));
    ticks(5);
    for (int f = 0; f < 3; f++) begin
      wr(f % 4, NS'($urandom), 1);
      ticks(4);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {seg_lvl_o, com_lvl_o}, '0);
    rst_ni = 1;
    @(negedge clk);
    cur_req = "R7";
    ticks(3);
    check("R7 off", {seg_lvl_o, com_lvl_o}, '0);
    // three static frames done: polarity now 1
    cur_req = "R8";
    wr(0, NS'(1));
    wr(4, NS'(8));
    check("R8 pending row", 64'(seg(0)), 64'd0);
    ticks(1);
    cur_req = "R6";
    check("R6 static lit", 64'(seg(0)), 64'd0);
    check("R6 static unlit", 64'(seg(1)), 64'd3);
    check("R5 static com0", 64'(com(0)), 64'd3);
    check("R5 static com3", 64'(com(3)), 64'd3);
    cur_req = "R5";
    wr(4, NS'(8 | 4));
    ticks(1);
    check("R5 selected", 64'(com(0)), 64'd0);
    check("R5 nonselected", 64'(com(1)), 64'd2);
    check("R6 third lit", 64'(seg(0)), 64'd3);
    check("R6 third unlit", 64'(seg(1)), 64'd1);
    run_mode(4, "R4");
    run_mode(3, "R5");
    run_mode(2, "R2");
    run_mode(1, "R6");
    run_mode(0, "R8");
    run_mode(3, "R10");
    cur_req = "R3";
    wr(4, NS'(8 | 2));
    ticks(4);
    wr(4, NS'(8 | 7));
    ticks(9);
    cur_req = "R10";
    wr(6, '1);
    wr(7, '1);
    ticks(4);
    cur_req = "R9";
    wr(5, NS'({2'b10, 8'hA5}));
    wr(4, NS'(2));
    check("R9 port bit4", 64'(seg(24)), 64'd0);
    check("R9 port bit5", 64'(seg(25)), 64'd3);
    check("R9 port bit7", 64'(seg(27)), 64'd3);
    check("R7 lcd pin dark", 64'(seg(20)), 64'd0);
    check("R7 com dark", 64'(com_lvl_o), 64'd0);
    wr(5, NS'({2'b11, 8'h0F}));
    wr(4, NS'(8 | 3));
    ticks(6);
    check("R9 port bit0", 64'(seg(20)), 64'd3);
    check("R9 port bit7 low", 64'(seg(27)), 64'd0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule